// File: doc/BRIEF.md
# Transmit Buffer Empty Interrupt Controller

This block holds the transmit-side interrupt state for a bank of serial channels. Each channel keeps three bits: an interrupt enable, a pending flag and an under-service flag. While the enable is set, the pending flag is raised when the channel's transmit holding buffer becomes free to take another byte. In synchronous operation it is also raised once the trailing check sequence of a frame has gone out, even though the buffer-free status is low at that point.

Software clears the pending flag in one of two ways: it writes the next byte to the channel's data register, or it issues an explicit clear-pending command. An interrupt request is presented for a channel when its flag is pending, its enable is set and it is not already under service. An acknowledge puts the channel under service, which masks the request. An end-of-interrupt strobe takes it out of service again. The channels are fully independent, and each input and output carries one bit per channel.

Top module: `tbe_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every channel's enable, pending and under-service bits are cleared at that edge, so `pend` and `irq_req` read 0 afterwards.
- R2: A clock edge with `en_wr[i]` high loads `en_wdata[i]` into channel i's enable. The new value takes effect on the following edge.
- R3: With channel i enabled, a 0-to-1 change of `txbuf_rdy[i]` between two consecutive edges sets `pend[i]` at the second edge. A `txbuf_rdy[i]` that stays high does not set it again after it has been cleared.
- R4: With channel i enabled and `sync_mode[i]` high, an edge with `crc_sent[i]` high while `txbuf_rdy[i]` is low sets `pend[i]`. With `sync_mode[i]` low, `crc_sent[i]` has no effect.
- R5: An edge with `data_wr[i]` high clears `pend[i]`.
- R6: An edge with `clr_pend_cmd[i]` high clears `pend[i]`.
- R7: When a clear (R5 or R6) and a set (R3 or R4) fall on the same edge, the clear wins and `pend[i]` reads 0.
- R8: While the enable is clear, no event sets `pend[i]`. Clearing the enable does not clear a flag that is already pending, but it does drop `irq_req[i]`.
- R9: `irq_req[i]` is high exactly when channel i is pending, enabled and not under service.
- R10: An edge with `int_ack[i]` high while `irq_req[i]` is high puts the channel under service, which forces `irq_req[i]` low. An edge with `int_eoi[i]` high (and no such acknowledge) takes it out of service.
- R11: Inputs for one channel never change the state or outputs of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | NUM_CH | Per-channel enable write strobe |
| en_wdata | input | NUM_CH | Enable value written when the strobe is high |
| txbuf_rdy | input | NUM_CH | Transmit buffer can accept a byte (level) |
| crc_sent | input | NUM_CH | Pulse: check sequence finished sending |
| sync_mode | input | NUM_CH | Channel runs in a synchronous framing mode |
| data_wr | input | NUM_CH | Pulse: data register written |
| clr_pend_cmd | input | NUM_CH | Pulse: clear-pending command |
| int_ack | input | NUM_CH | Pulse: interrupt acknowledge |
| int_eoi | input | NUM_CH | Pulse: end of interrupt service |
| pend | output | NUM_CH | Pending flag per channel |
| irq_req | output | NUM_CH | Interrupt request per channel |

## Verification
The assertions take for granted that every input is a clean, synchronous level sampled at the rising edge. They make no assumption about pulse widths, because each strobe is treated as one event per high edge. The random phase holds each channel's buffer-ready level for several cycles and toggles it at random, so that genuine rising edges occur. It also issues acknowledges both with and without a live request, and places clears and sets on the same edge on purpose, so that the priority rules are exercised rather than avoided.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

    // Per-channel architectural state.
    typedef struct packed {
        logic en;    // interrupt enable
        logic pend;  // interrupt pending
        logic ius;   // interrupt under service
    } tbe_state_t;

    localparam tbe_state_t TBE_RESET = '{en: 1'b0, pend: 1'b0, ius: 1'b0};

    // Per-channel control inputs as seen at one clock edge.
    typedef struct packed {
        logic en_wr;
        logic en_val;
        logic set_evt;
        logic clr_evt;
        logic ack;
        logic eoi;
    } tbe_ctl_t;

    function automatic logic tbe_req(tbe_state_t s);
        return s.pend & s.en & ~s.ius;
    endfunction

    // Clear beats set; acknowledge of a live request beats end-of-interrupt.
    function automatic tbe_state_t tbe_next(tbe_state_t s, tbe_ctl_t c);
        tbe_state_t n;
        n = s;
        if (c.en_wr)
            n.en = c.en_val;
        if (c.clr_evt)
            n.pend = 1'b0;
        else if (c.set_evt)
            n.pend = 1'b1;
        if (c.ack && tbe_req(s))
            n.ius = 1'b1;
        else if (c.eoi)
            n.ius = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/tbe_event_gen.sv
module tbe_event_gen (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic txbuf_rdy,
    input  logic crc_sent,
    input  logic sync_mode,
    output logic set_evt
);

    logic rdy_q;
    logic rdy_rise;
    logic crc_hit;

    always_ff @(posedge clk) begin
        if (rst)
            rdy_q <= 1'b0;
        else
            rdy_q <= txbuf_rdy;
    end

    assign rdy_rise = txbuf_rdy & ~rdy_q;
    assign crc_hit  = sync_mode & crc_sent & ~txbuf_rdy;
    assign set_evt  = en & (rdy_rise | crc_hit);

    // R2 / R8: a disabled channel never produces a set event.
    p_no_set_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !set_evt);

    // R4: without synchronous mode and without buffer-ready, nothing sets.
    p_async_crc_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && !txbuf_rdy) |-> !set_evt);

endmodule

// File: rtl/tbe_chan_state.sv
module tbe_chan_state
    import tbe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_wr,
    input  logic en_val,
    input  logic set_evt,
    input  logic data_wr,
    input  logic clr_cmd,
    input  logic ack,
    input  logic eoi,
    output logic en_q,
    output logic pend,
    output logic irq_req
);

    tbe_state_t st;
    tbe_ctl_t   ctl;

    always_comb begin
        ctl.en_wr   = en_wr;
        ctl.en_val  = en_val;
        ctl.set_evt = set_evt;
        ctl.clr_evt = data_wr | clr_cmd;
        ctl.ack     = ack;
        ctl.eoi     = eoi;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= TBE_RESET;
        else
            st <= tbe_next(st, ctl);
    end

    assign en_q    = st.en;
    assign pend    = st.pend;
    assign irq_req = tbe_req(st);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!pend && !irq_req));

    p_set_takes_r3: assert property (@(posedge clk) disable iff (rst)
        (set_evt && !data_wr && !clr_cmd) |=> pend);

    p_data_wr_clears_r5: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> !pend);

    p_cmd_clears_r6: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> !pend);

    p_enable_load_r2: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_q == $past(en_val)));

    p_ack_masks_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req) |=> !irq_req);

    p_eoi_unmasks_r10: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack && pend && en_q && !data_wr && !clr_cmd && !en_wr) |=> irq_req);

endmodule

// File: rtl/tbe_irq_ctrl.sv
module tbe_irq_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] en_wr,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic [NUM_CH-1:0] txbuf_rdy,
    input  logic [NUM_CH-1:0] crc_sent,
    input  logic [NUM_CH-1:0] sync_mode,
    input  logic [NUM_CH-1:0] data_wr,
    input  logic [NUM_CH-1:0] clr_pend_cmd,
    input  logic [NUM_CH-1:0] int_ack,
    input  logic [NUM_CH-1:0] int_eoi,
    output logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] irq_req
);

    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] set_evt;

    // R11: one independent slice per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tbe_event_gen u_evt (
            .clk       (clk),
            .rst       (rst),
            .en        (en_q[i]),
            .txbuf_rdy (txbuf_rdy[i]),
            .crc_sent  (crc_sent[i]),
            .sync_mode (sync_mode[i]),
            .set_evt   (set_evt[i])
        );

        tbe_chan_state u_st (
            .clk     (clk),
            .rst     (rst),
            .en_wr   (en_wr[i]),
            .en_val  (en_wdata[i]),
            .set_evt (set_evt[i]),
            .data_wr (data_wr[i]),
            .clr_cmd (clr_pend_cmd[i]),
            .ack     (int_ack[i]),
            .eoi     (int_eoi[i]),
            .en_q    (en_q[i]),
            .pend    (pend[i]),
            .irq_req (irq_req[i])
        );
    end

    // R9: a request always implies a pending flag.
    p_req_needs_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~pend) == '0);

endmodule

// File: tb/tbe_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tbe_irq_ctrl_bench;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] en_wr = '0, en_wdata = '0, txbuf_rdy = '0, crc_sent = '0;
    logic [NCH-1:0] sync_mode = '0, data_wr = '0, clr_pend_cmd = '0;
    logic [NCH-1:0] int_ack = '0, int_eoi = '0;
    logic [NCH-1:0] pend, irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench reference state, written from the requirements.
    logic [NCH-1:0] m_en = '0, m_pend = '0, m_ius = '0, m_rdyq = '0;

    always #2.5 clk = ~clk;

    tbe_irq_ctrl #(.NUM_CH(NCH)) u_tbe_irq_ctrl (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .txbuf_rdy(txbuf_rdy), .crc_sent(crc_sent), .sync_mode(sync_mode),
        .data_wr(data_wr), .clr_pend_cmd(clr_pend_cmd), .int_ack(int_ack),
        .int_eoi(int_eoi), .pend(pend), .irq_req(irq_req)
    );

    function automatic logic [NCH-1:0] exp_req(logic [NCH-1:0] p, logic [NCH-1:0] e,
                                                logic [NCH-1:0] s);
        return p & e & ~s;
    endfunction

    task automatic model_edge();
        logic [NCH-1:0] set_v, clr_v, req_v;
        req_v = exp_req(m_pend, m_en, m_ius);
        if (rst) begin
            m_en = '0; m_pend = '0; m_ius = '0; m_rdyq = '0;
        end else begin
            set_v = m_en & ((txbuf_rdy & ~m_rdyq) | (sync_mode & crc_sent & ~txbuf_rdy));
            clr_v = data_wr | clr_pend_cmd;
            m_pend = (m_pend | set_v) & ~clr_v;
            m_ius  = (int_ack & req_v) | (m_ius & ~int_eoi);
            m_en   = (m_en & ~en_wr) | (en_wdata & en_wr);
            m_rdyq = txbuf_rdy;
        end
    endtask

    task automatic chk(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One clock edge: update model, sample after the edge, drop pulses.
    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        en_wr = '0; crc_sent = '0; data_wr = '0; clr_pend_cmd = '0;
        int_ack = '0; int_eoi = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        txbuf_rdy = 4'b0100;  // high during reset: no stale edge afterwards if disabled
        repeat (3) tick();
        chk("R1 pend after reset", pend, '0);
        chk("R1 req after reset", irq_req, '0);
        rst = 1'b0;
        txbuf_rdy = '0;
        tick();

        // R2 + R3: enable ch0, then buffer becomes ready.
        en_wr = 4'b0001; en_wdata = 4'b0001; tick();
        chk("R2 enable alone sets nothing", pend, '0);
        txbuf_rdy[0] = 1'b1; tick();
        chk("R3 rise sets pend", pend, 4'b0001);
        chk("R9 req follows pend", irq_req, 4'b0001);

        // R6 then R3 level does not re-set.
        clr_pend_cmd[0] = 1'b1; tick();
        chk("R6 command clears", pend, '0);
        tick();
        chk("R3 steady level no re-set", pend, '0);

        // R5: new rise then data write.
        txbuf_rdy[0] = 1'b0; tick();
        txbuf_rdy[0] = 1'b1; tick();
        chk("R3 second rise", pend, 4'b0001);
        data_wr[0] = 1'b1; tick();
        chk("R5 data write clears", pend, '0);

        // R4: sync CRC with ready low.
        txbuf_rdy[0] = 1'b0; sync_mode[0] = 1'b1; tick();
        crc_sent[0] = 1'b1; tick();
        chk("R4 sync crc sets", pend, 4'b0001);
        clr_pend_cmd[0] = 1'b1; sync_mode[0] = 1'b0; tick();
        crc_sent[0] = 1'b1; tick();
        chk("R4 async crc ignored", pend, '0);

        // R7: clear and rise on the same edge.
        txbuf_rdy[0] = 1'b1; data_wr[0] = 1'b1; tick();
        chk("R7 clear beats set", pend, '0);

        // R8: disabled channel not set; disabling keeps pend, drops req.
        txbuf_rdy[0] = 1'b0; en_wr[0] = 1'b1; en_wdata[0] = 1'b0; tick();
        txbuf_rdy[0] = 1'b1; tick();
        chk("R8 disabled no set", pend, '0);
        txbuf_rdy[0] = 1'b0; en_wr[0] = 1'b1; en_wdata[0] = 1'b1; tick();
        txbuf_rdy[0] = 1'b1; tick();
        en_wr[0] = 1'b1; en_wdata[0] = 1'b0; tick();
        chk("R8 pend kept on disable", pend, 4'b0001);
        chk("R8 req dropped on disable", irq_req, '0);

        // R10: acknowledge masks, end-of-interrupt unmasks.
        en_wr[0] = 1'b1; en_wdata[0] = 1'b1; tick();
        chk("R9 req back with enable", irq_req, 4'b0001);
        int_ack[0] = 1'b1; tick();
        chk("R10 ack masks req", irq_req, '0);
        chk("R10 ack keeps pend", pend, 4'b0001);
        int_eoi[0] = 1'b1; tick();
        chk("R10 eoi restores req", irq_req, 4'b0001);

        // R11: other channels untouched by all of the above.
        chk("R11 channels isolated", pend[3:1], 3'b000);

        // Random phase against the bench model (R11 across all channels).
        for (int n = 0; n < 3000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(0, 5) == 0) txbuf_rdy[c] = ~txbuf_rdy[c];
                if ($urandom_range(0, 15) == 0) sync_mode[c] = ~sync_mode[c];
                en_wr[c]        = ($urandom_range(0, 19) == 0);
                en_wdata[c]     = ($urandom_range(0, 3) != 0);
                crc_sent[c]     = ($urandom_range(0, 5) == 0);
                data_wr[c]      = ($urandom_range(0, 7) == 0);
                clr_pend_cmd[c] = ($urandom_range(0, 9) == 0);
                int_ack[c]      = ($urandom_range(0, 5) == 0);
                int_eoi[c]      = ($urandom_range(0, 6) == 0);
            end
            if (n == 1500) rst = 1'b1;
            if (n == 1502) rst = 1'b0;
            tick();
            chk("R11 random pend", pend, m_pend);
            chk("R11 random req", irq_req, exp_req(m_pend, m_en, m_ius));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule